// File: doc/BRIEF.md
# Release-Triggered Button Option Controller

This block turns one push button into a user setting. The button level arrives active low and already synchronized to the clock. A five-state machine debounces it. The machine looks at the button only on cycles where a sample-enable tick is high, for example once per millisecond. Each debounce check therefore confirms the level across one tick interval.

A press counts only after the button has been released and that release has been confirmed. The press itself changes nothing. When a press counts, the machine spends exactly one clock in an action state. On the clock that follows, the option register changes and a notify line inverts its level, so that a peer unit watching the line can apply the same change. A parameter selects one of two variants for each instance: a binary option that flips, or a three-valued speed option that steps slow, medium, fast and back to slow.

The states are Idle, PressCheck, Held, ReleaseCheck and Act. The transitions on a tick are as follows.
- Idle goes to PressCheck when the button is low, and stays in Idle when it is high.
- PressCheck goes to Held when the button is still low, and back to Idle when it is high.
- Held stays in Held while the button is low, and goes to ReleaseCheck when it is high.
- ReleaseCheck goes to Act when the button is still high, and back to Held when it is low.
- Act goes to Idle on the next clock, whatever the tick or the button do.

Top module: `btn_option_ctrl`

## Requirements
- R1: During and after reset, the machine is in Idle, the option is 0 (slow in the three-way variant) and notify is 0.
- R2: The button is active low (0 means pressed). On a cycle where sample_en is 0, the state does not change, except when leaving Act.
- R3: On a tick, Idle moves to PressCheck if btn_n is 0. On a tick, PressCheck moves to Held if btn_n is 0, and returns to Idle if btn_n is 1. A press seen on only one tick therefore has no effect.
- R4: On a tick, Held stays in Held while btn_n is 0, and moves to ReleaseCheck when btn_n is 1.
- R5: On a tick, ReleaseCheck moves to Act if btn_n is 1, and returns to Held if btn_n is 0. A release seen on only one tick therefore does not count the press.
- R6: Act lasts exactly one clock and is always followed by Idle.
- R7: In the binary variant (THREE_WAY = 0), bit 0 of the option inverts on each counted press, and bit 1 stays 0.
- R8: In the three-way variant (THREE_WAY = 1), the option is encoded as slow = 0, medium = 1 and fast = 2. It steps 0, 1, 2, 0 on successive counted presses and never holds 3.
- R9: notify inverts its level exactly once for each counted press, on the same clock as the option change.
- R10: The option and notify change only on the clock after Act. They never change while the button is held or before a release has been confirmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_en | input | 1 | Tick on which the button level is evaluated |
| btn_n | input | 1 | Synchronized button level, 0 = pressed |
| option | output | 2 | Current option value |
| notify | output | 1 | Level that inverts on each counted press |

## Verification
The option and notify respond to a tick with a delay of two clocks. On the edge that carries the confirming tick, the machine enters Act. On the next edge, whether or not a tick is present, the option and notify change. Each tick in the bench is therefore driven on a falling edge, removed on the next falling edge, and the outputs are sampled on the falling edge after that, when both edges have passed. The expected option and notify come from a step model of the transition list and a count of counted presses, reduced modulo 2 or 3.

// File: rtl/btnopt_pkg.sv
package btnopt_pkg;

    // Width of the option register shared by both variants
    localparam int OPT_W = 2;

    // Debounce machine states
    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_PRESS_CHK   = 3'd1,
        ST_HELD        = 3'd2,
        ST_RELEASE_CHK = 3'd3,
        ST_ACT         = 3'd4
    } btn_state_e;

    // Three-way speed option encoding
    typedef enum logic [OPT_W-1:0] {
        SPD_SLOW = 2'd0,
        SPD_MED  = 2'd1,
        SPD_FAST = 2'd2
    } spd_e;

endpackage

// File: rtl/btnopt_fsm.sv
module btnopt_fsm
    import btnopt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic btn_n,
    output logic fire
);

    btn_state_e state_q;
    btn_state_e state_d;
    logic       pressed;

    assign pressed = ~btn_n;

    // Next-state logic: evaluated only on ticks, except that Act always leaves
    always_comb begin
        state_d = state_q;
        if (state_q == ST_ACT) begin
            state_d = ST_IDLE;
        end else if (sample_en) begin
            unique case (state_q)
                ST_IDLE:        state_d = pressed ? ST_PRESS_CHK : ST_IDLE;
                ST_PRESS_CHK:   state_d = pressed ? ST_HELD      : ST_IDLE;
                ST_HELD:        state_d = pressed ? ST_HELD      : ST_RELEASE_CHK;
                ST_RELEASE_CHK: state_d = pressed ? ST_HELD      : ST_ACT;
                default:        state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            ST_ACT:  fire = 1'b1;
            default: fire = 1'b0;
        endcase
    end

    // R6: Act lasts exactly one clock and is always followed by Idle
    a_r6_act_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_ACT |=> state_q == ST_IDLE);

    // R2: without a tick, the state holds unless it is leaving Act
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en && state_q != ST_ACT) |=> $stable(state_q));

    // R3: an idle machine with the button up stays idle
    a_r3_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && sample_en && btn_n) |=> state_q == ST_IDLE);

    // R5: a confirmed release always leads into Act
    a_r5_release_to_act: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASE_CHK && sample_en && btn_n) |=> state_q == ST_ACT);

    // R4: Held is never left while the button stays down
    a_r4_held_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && !btn_n) |=> state_q == ST_HELD);

endmodule

// File: rtl/btnopt_option.sv
module btnopt_option
    import btnopt_pkg::*;
#(
    parameter bit THREE_WAY = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    output logic [OPT_W-1:0] opt_o
);

    generate
        if (THREE_WAY) begin : g_three
            spd_e spd_q;
            spd_e spd_d;

            // Step slow -> medium -> fast -> slow
            always_comb begin
                spd_d = spd_q;
                if (fire) begin
                    unique case (spd_q)
                        SPD_SLOW: spd_d = SPD_MED;
                        SPD_MED:  spd_d = SPD_FAST;
                        SPD_FAST: spd_d = SPD_SLOW;
                        default:  spd_d = SPD_SLOW;
                    endcase
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    spd_q <= SPD_SLOW;
                end else begin
                    spd_q <= spd_d;
                end
            end

            assign opt_o = spd_q;

            // R8: the unused code 3 never appears
            a_r8_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
                opt_o != 2'd3);

            // R8: a step from fast wraps back to slow
            a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
                (fire && opt_o == 2'd2) |=> opt_o == 2'd0);
        end else begin : g_bin
            logic flag_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flag_q <= 1'b0;
                end else if (fire) begin
                    flag_q <= ~flag_q;
                end
            end

            assign opt_o = {1'b0, flag_q};

            // R7: the binary option is inverted on every action
            a_r7_flip: assert property (@(posedge clk) disable iff (!rst_n)
                fire |=> opt_o[0] != $past(opt_o[0]));
        end
    endgenerate

    // R10: the option stays put unless an action occurred
    a_r10_no_change_without_fire: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(opt_o));

endmodule

// File: rtl/btnopt_notify.sv
module btnopt_notify (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic notify_o
);

    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else if (fire) begin
            level_q <= ~level_q;
        end
    end

    assign notify_o = level_q;

    // R9: the notify level inverts once per action, and only then
    a_r9_flip_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> notify_o != $past(notify_o));

    a_r9_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(notify_o));

endmodule

// File: rtl/btn_option_ctrl.sv
module btn_option_ctrl
    import btnopt_pkg::*;
#(
    parameter bit THREE_WAY = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             btn_n,
    output logic [OPT_W-1:0] option,
    output logic             notify
);

    logic fire;

    btnopt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .btn_n     (btn_n),
        .fire      (fire)
    );

    btnopt_option #(
        .THREE_WAY (THREE_WAY)
    ) u_option (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .opt_o (option)
    );

    btnopt_notify u_notify (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .notify_o (notify)
    );

    // R9: the option and the notify line move on the same clock
    a_r9_moves_together: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(option) |-> !$stable(notify));

    // R1: the outputs are at their reset values while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_values: assert (option == '0 && notify == 1'b0);
        end
    end

endmodule

// File: tb/btn_option_ctrl_test.sv
`timescale 1ns/1ps
module btn_option_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en = 1'b0;
    logic       btn_n = 1'b1;
    logic [1:0] opt3;
    logic [1:0] opt2;
    logic       ntf3;
    logic       ntf2;

    int n_chk = 0;
    int n_bad = 0;
    int m_state = 0;
    int presses = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    btn_option_ctrl #(.THREE_WAY(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .btn_n(btn_n),
        .option(opt3), .notify(ntf3)
    );

    btn_option_ctrl #(.THREE_WAY(1'b0)) uut_bin (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .btn_n(btn_n),
        .option(opt2), .notify(ntf2)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare both instances with the count of counted presses
    task automatic chk_all(input string tag);
        chk({tag, " R8 three-way option"}, int'(opt3), presses % 3);
        chk({tag, " R7 binary option"}, int'(opt2), presses % 2);
        chk({tag, " R9 notify three-way"}, int'(ntf3), presses % 2);
        chk({tag, " R9 notify binary"}, int'(ntf2), presses % 2);
    endtask

    // Model: 0 Idle, 1 PressCheck, 2 Held, 3 ReleaseCheck
    task automatic model_step(input logic b);
        case (m_state)
            0: m_state = b ? 0 : 1;
            1: m_state = b ? 0 : 2;
            2: m_state = b ? 3 : 2;
            default: begin
                if (b) begin
                    presses++;
                    m_state = 0;
                end else begin
                    m_state = 2;
                end
            end
        endcase
    endtask

    // One tick, then one idle clock, then sample
    task automatic tick(input logic b);
        @(negedge clk);
        btn_n = b;
        sample_en = 1'b1;
        @(negedge clk);
        sample_en = 1'b0;
        @(negedge clk);
        model_step(b);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 option in reset", int'(opt3), 0);
        chk("R1 notify in reset", int'(ntf3), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 three-way option after reset", int'(opt3), 0);
        chk("R1 binary option after reset", int'(opt2), 0);
        chk("R1 notify after reset", int'(ntf2), 0);

        // R10: held press changes nothing before the release is confirmed
        tick(1'b0); tick(1'b0); tick(1'b0); tick(1'b0);
        chk_all("R10 held");
        tick(1'b1);
        chk_all("R10 one release tick");
        tick(1'b1);
        chk("R10 counted press", presses, 1);
        chk_all("R10 after confirm");

        // R3: single-tick glitch is rejected
        tick(1'b0); tick(1'b1); tick(1'b1); tick(1'b1);
        chk("R3 glitch press count", presses, 1);
        chk_all("R3 glitch");

        // R5: bounce on release returns to Held, one press counted
        tick(1'b0); tick(1'b0); tick(1'b1); tick(1'b0); tick(1'b1);
        chk_all("R5 bounce before confirm");
        tick(1'b1);
        chk("R5 bounce press count", presses, 2);
        chk_all("R5 after bounce");

        // R2: input ignored without ticks, state observed via later ticks
        tick(1'b0); tick(1'b0);
        @(negedge clk);
        btn_n = 1'b1;
        repeat (20) @(negedge clk);
        chk_all("R2 no tick window");
        tick(1'b0);
        chk_all("R2 still held");
        tick(1'b1); tick(1'b1);
        chk("R2 press count", presses, 3);
        chk_all("R2 after ignored window");

        // R8: third press wrapped to slow; R6: Act leaves to Idle
        chk("R8 wrap to slow", int'(opt3), 0);
        tick(1'b0); tick(1'b1);
        chk_all("R6 idle after act");

        // R4 with R3 and R5: exhaustive eight-tick pattern sweep
        for (int p = 0; p < 256; p++) begin
            for (int i = 0; i < 8; i++) begin
                tick(p[i]);
                chk_all("R4 sweep");
            end
        end

        // Back-to-back ticks every clock
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            btn_n = (k % 5) > 1;
            sample_en = 1'b1;
        end
        @(negedge clk);
        sample_en = 1'b0;
        btn_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R6 continuous ticks option stays legal", int'(opt3 != 2'd3), 1);

        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

endmodule